// File: doc/BRIEF.md
# DMA Interrupt Status Controller

This block holds the 32-bit interrupt control and status word of a seven-channel DMA engine and raises the single DMA interrupt request toward the CPU. Each channel reports the end of a transfer with a one-cycle completion pulse. The block records that completion as a per-channel flag, decides whether the interrupt condition holds, and keeps a sticky master flag that software clears by acknowledging the channel flags.

Software reaches the word through one write port with four byte lanes and a read port that always shows the current value. Bits 23:0 are plain configuration. Bits 22:16 are per-channel enables, bit 23 is the master enable, and bits 15:0 are held but have no effect here. Bits 30:24 are completion flags that software clears by writing a one to them. Bit 31 is the master interrupt flag. It is modelled as a two-state machine, `ST_QUIET` (bit 31 clear) and `ST_RAISED` (bit 31 set). Two transitions are named. RAISE goes from `ST_QUIET` to `ST_RAISED` when a completion finds the interrupt condition true. DRAIN goes from `ST_RAISED` to `ST_QUIET` when a write leaves every completion flag at zero. The interrupt request is a one-cycle pulse issued on the RAISE transition.

Top module: `dma_irq_status`

## Requirements
- R1: Reset sets the whole register to 0x00000000 and holds `irq_pulse` low.
- R2: A write (`wr_en`=1) replaces register byte k, for k = 0, 1 and 2 (bits 8k+7:8k), with the matching byte of `wr_data` when `wr_be[k]`=1. Bytes whose lane bit is 0 keep their value. Nothing changes these bits when there is no write.
- R3: A write with `wr_be[3]`=1 clears each flag in bits 30:24 where `wr_data` holds a 1 and leaves the other flags unchanged. With `wr_be[3]`=0 the write leaves the flags unchanged.
- R4: No write can set bit 31, whatever the data or the lane mask.
- R5: A pulse on `done_i[n]` sets flag bit 24+n when enable bit 16+n is 1.
- R6: A completion event checks every flag after the new flags are set. Each flag whose enable bit (eight positions lower) is 0 is cleared, so a completion on a channel whose enable is off leaves no flag behind. Flags are only dropped in a cycle that has a completion event.
- R7: Bit 31 is set, and the machine takes RAISE, only in a cycle with a completion event, the master enable (bit 23) at 1, and at least one flag whose enable is also 1. With the master enable at 0 the flags still latch, but bit 31 stays 0. Turning on the master enable by a write alone does not set bit 31.
- R8: `irq_pulse` is high for exactly one cycle, in the cycle where bit 31 first reads 1 after having been 0. If bit 31 is already set, a further qualifying completion gives no pulse.
- R9: Any write (with any lane mask, including none) that leaves bits 30:24 all zero while bit 31 is set clears bit 31 (DRAIN). If a flag remains set, bit 31 stays. A completion event never clears bit 31.
- R10: When a write and a completion event fall in the same cycle, the write is applied first (byte replacement, flag clearing, DRAIN), and then the completion is set and evaluated against the enables as just written. `irq_pulse` follows the visible value of bit 31, so a DRAIN followed by RAISE in the same cycle produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_i | input | 7 | Per-channel completion pulses, bit n for channel n |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte-lane mask for the write, bit k for bits 8k+7:8k |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| irq_pulse | output | 1 | One-cycle interrupt request to the CPU |

## Verification
The assertions assume that `done_i`, `wr_en`, `wr_be` and `wr_data` are known and stable around each rising edge once reset is released. They also assume that the channel count fits within the seven flag positions. No assumption is made about how completion pulses and writes overlap, because overlap is exactly what R10 defines. The stimulus changes every input only on the falling edge, and each vector holds its inputs for a full cycle. The vectors deliberately combine writes and completions in the same cycle, set flags with the master enable off, and issue an empty-mask write while bit 31 is set.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    // Word layout; the positions are decoded by software and the CPU side.
    localparam int REG_W      = 32;
    localparam int CH_LIMIT   = 7;
    localparam int BYTE_W     = 8;
    localparam int CFG_W      = 24;
    localparam int CFG_BYTES  = CFG_W / BYTE_W;
    localparam int EN_LSB     = 16;
    localparam int MEN_BIT    = 23;
    localparam int FLAG_LSB   = 24;
    localparam int FLAG_LANE  = FLAG_LSB / BYTE_W;
    localparam int MFLAG_BIT  = 31;
    localparam int LANES      = REG_W / BYTE_W;

    // Master interrupt flag as a two-state machine.
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } mflag_state_e;

endpackage

// File: rtl/dmairq_cfg_reg.sv
module dmairq_cfg_reg
    import dmairq_pkg::*;
#(
    parameter int WIDTH = CFG_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [WIDTH/BYTE_W-1:0]   wr_be,
    input  logic [WIDTH-1:0]          wr_data,
    output logic [WIDTH-1:0]          cfg_q,
    output logic [WIDTH-1:0]          cfg_next
);

    localparam int NB = WIDTH / BYTE_W;

    // Per-lane replacement, the value seen by this cycle's evaluation.
    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_comb begin
            if (wr_en && wr_be[b]) begin
                cfg_next[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
            end else begin
                cfg_next[b*BYTE_W +: BYTE_W] = cfg_q[b*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_next;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/dmairq_flag_bank.sv
module dmairq_flag_bank
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = CH_LIMIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [NUM_CH-1:0] clr_mask,
    input  logic [NUM_CH-1:0] done_i,
    input  logic [NUM_CH-1:0] en_q,
    input  logic [NUM_CH-1:0] en_next,
    input  logic              men_next,
    output logic [NUM_CH-1:0] flags_q,
    output logic              post_wr_zero,
    output logic              hit
);

    logic [NUM_CH-1:0] clr_bits;
    logic [NUM_CH-1:0] post_wr;
    logic [NUM_CH-1:0] with_done;
    logic [NUM_CH-1:0] flags_next;
    logic              event_seen;

    // Write first: clear-on-one within the flag lane.
    always_comb begin
        clr_bits     = clr_en ? clr_mask : '0;
        post_wr      = flags_q & ~clr_bits;
        post_wr_zero = (post_wr == '0);
    end

    // Completion second: set, evaluate, then drop the unenabled flags.
    always_comb begin
        with_done  = post_wr | done_i;
        event_seen = |done_i;
        hit        = event_seen && men_next && (|(with_done & en_next));
        flags_next = event_seen ? (with_done & en_next) : post_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_next;
        end
    end

    AST_DROP_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_i) |=> ((flags_q & ~en_q) == '0)); // R6

    AST_LATCH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_i) |=> ((flags_q & $past(done_i & en_next)) == $past(done_i & en_next))); // R5

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && !(|done_i)) |=> (flags_q == $past(flags_q))); // R3

endmodule

// File: rtl/dmairq_master_fsm.sv
module dmairq_master_fsm
    import dmairq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic post_wr_zero,
    input  logic hit,
    output logic mflag_q,
    output logic irq_pulse
);

    mflag_state_e state_q;
    mflag_state_e state_d;

    // Next state: DRAIN by the write, then RAISE by the completion.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (hit) begin
                    state_d = ST_RAISED;                     // RAISE
                end
            end
            ST_RAISED: begin
                if (wr_en && post_wr_zero && !hit) begin
                    state_d = ST_QUIET;                      // DRAIN
                end
            end
            default: state_d = ST_QUIET;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: one pulse on the visible rise of the master flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= (state_q == ST_QUIET) && (state_d == ST_RAISED);
        end
    end

    assign mflag_q = (state_q == ST_RAISED);

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R8

    AST_IRQ_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (state_q == ST_RAISED && $past(state_q) == ST_QUIET)); // R7

    AST_NO_WRITE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUIET && !hit) |=> (state_q == ST_QUIET)); // R4

    AST_DRAIN_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && post_wr_zero && !hit) |=> (state_q == ST_QUIET)); // R9

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = CH_LIMIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] done_i,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_be,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_pulse
);

    localparam int FLAG_TOP = FLAG_LSB + NUM_CH;

    logic [CFG_W-1:0]  cfg_q;
    logic [CFG_W-1:0]  cfg_next;
    logic [NUM_CH-1:0] flags_q;
    logic              post_wr_zero;
    logic              hit;
    logic              mflag_q;
    logic              unused_wr_top;

    // Bits above the flag field carry no write meaning.
    assign unused_wr_top = ^wr_data[REG_W-1:FLAG_TOP];

    dmairq_cfg_reg #(
        .WIDTH   (CFG_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be[CFG_BYTES-1:0]),
        .wr_data (wr_data[CFG_W-1:0]),
        .cfg_q   (cfg_q),
        .cfg_next(cfg_next)
    );

    dmairq_flag_bank #(
        .NUM_CH      (NUM_CH)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_en      (wr_en && wr_be[FLAG_LANE]),
        .clr_mask    (wr_data[FLAG_LSB +: NUM_CH]),
        .done_i      (done_i),
        .en_q        (cfg_q[EN_LSB +: NUM_CH]),
        .en_next     (cfg_next[EN_LSB +: NUM_CH]),
        .men_next    (cfg_next[MEN_BIT]),
        .flags_q     (flags_q),
        .post_wr_zero(post_wr_zero),
        .hit         (hit)
    );

    dmairq_master_fsm u_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .post_wr_zero(post_wr_zero),
        .hit         (hit),
        .mflag_q     (mflag_q),
        .irq_pulse   (irq_pulse)
    );

    always_comb begin
        rd_data                      = '0;
        rd_data[CFG_W-1:0]           = cfg_q;
        rd_data[FLAG_LSB +: NUM_CH]  = flags_q;
        rd_data[MFLAG_BIT]           = mflag_q;
    end

    AST_MFLAG_NEEDS_MEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[MFLAG_BIT]) |-> rd_data[MEN_BIT]); // R7

endmodule

// File: tb/dma_irq_status_tb.sv
`timescale 1ns/1ps
module dma_irq_status_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  done_i = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_pulse;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_irq_status u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (done_i),
        .wr_en    (wr_en),
        .wr_be    (wr_be),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq_pulse(irq_pulse)
    );

    // {wr_en, wr_be, wr_data, done_i, expected rd_data, expected irq_pulse}
    localparam int NV = 17;
    localparam logic [76:0] VEC [NV] = '{
        {1'b1, 4'b0111, 32'h00851234, 7'h00, 32'h00851234, 1'b0}, // R2 enables ch0, ch2, master
        {1'b0, 4'b0000, 32'h00000000, 7'h01, 32'h81851234, 1'b1}, // R5 R7 RAISE
        {1'b0, 4'b0000, 32'h00000000, 7'h04, 32'h85851234, 1'b0}, // R8 no second pulse
        {1'b0, 4'b0000, 32'h00000000, 7'h02, 32'h85851234, 1'b0}, // R6 unenabled dropped
        {1'b1, 4'b1000, 32'h01000000, 7'h00, 32'h84851234, 1'b0}, // R3 R9 partial clear
        {1'b1, 4'b1000, 32'h04000000, 7'h00, 32'h00851234, 1'b0}, // R9 DRAIN
        {1'b1, 4'b1111, 32'hFF000000, 7'h00, 32'h00000000, 1'b0}, // R4 R2 no write set
        {1'b1, 4'b0100, 32'h007F0000, 7'h00, 32'h007F0000, 1'b0}, // R2 all enables
        {1'b0, 4'b0000, 32'h00000000, 7'h48, 32'h487F0000, 1'b0}, // R7 master off
        {1'b1, 4'b0100, 32'h00FF0000, 7'h00, 32'h48FF0000, 1'b0}, // R7 write alone
        {1'b0, 4'b0000, 32'h00000000, 7'h01, 32'hC9FF0000, 1'b1}, // R7 RAISE
        {1'b1, 4'b1000, 32'h7F000000, 7'h02, 32'h82FF0000, 1'b0}, // R10 drain+raise
        {1'b1, 4'b0100, 32'h00800000, 7'h00, 32'h82800000, 1'b0}, // R9 flag keeps bit31
        {1'b0, 4'b0000, 32'h00000000, 7'h10, 32'h80800000, 1'b0}, // R6 drop all
        {1'b1, 4'b0000, 32'hFFFFFFFF, 7'h00, 32'h00800000, 1'b0}, // R9 empty mask
        {1'b1, 4'b0100, 32'h00810000, 7'h01, 32'h81810000, 1'b1}, // R10 enable first
        {1'b0, 4'b0000, 32'h00000000, 7'h00, 32'h81810000, 1'b0}  // R8 one cycle
    };

    function automatic string vtag(input int i);
        case (i)
            0: return "R2";
            1: return "R5/R7";
            2: return "R8";
            3: return "R6";
            4: return "R3/R9";
            5: return "R9";
            6: return "R4";
            7: return "R2";
            8: return "R7";
            9: return "R7";
            10: return "R7";
            11: return "R10";
            12: return "R9";
            13: return "R6";
            14: return "R9";
            15: return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reg", rd_data, 32'h0);
        check("R1 irq", {31'h0, irq_pulse}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en   = VEC[i][76];
            wr_be   = VEC[i][75:72];
            wr_data = VEC[i][71:40];
            done_i  = VEC[i][39:33];
            @(posedge clk);
            #1;
            check(vtag(i), rd_data, VEC[i][32:1]);
            check(vtag(i), {31'h0, irq_pulse}, {31'h0, VEC[i][0]});
        end
        // R1 reset from a loaded state
        @(negedge clk);
        wr_en = 1'b0; done_i = '0; wr_be = '0; wr_data = '0;
        rst_n = 1'b0;
        #1;
        check("R1 reg", rd_data, 32'h0);
        check("R1 irq", {31'h0, irq_pulse}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R6 completion on disabled channel after reset leaves nothing
        @(negedge clk);
        done_i = 7'h7F;
        @(negedge clk);
        done_i = '0;
        check("R6", rd_data, 32'h0);
        finish_run();
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected done");
            finish_run();
        end
    end

endmodule